// File: doc/BRIEF.md
# Multi-Pattern Bit Error Rate Test Sequence Generator

This block produces the serial transmit stream for a bit error rate test on a T1-rate line. One select code picks the pattern. The choices are six maximal-length pseudo-random sequences, a quasi-random variant with limited zero runs, two fixed ones-density words, an alternating pattern, and a clear mode. In clear mode the received data is looped back to the transmit side. The select code is read only when a test is started. Moving the select lines while idle or during a test has no effect on the bits sent.

A test runs from a start pulse until a stop pulse arrives or until a programmed number of bits has been sent. The surrounding line logic supplies a strobe, and the block emits one bit for each strobe cycle. When no test is running, the output rests at one. Framing, channel placement and line coding belong to neighbouring blocks.

Top module: `bert_patgen`

## Requirements
- R1: `tx_bit` is 1 whenever no test is running: after reset, before the first start, after a stop and after the bit budget is used up.
- R2: `pat_sel` and `len_limit` are captured only in a cycle with `start`=1. Changing `pat_sel` while idle or during a test leaves `tx_bit` unchanged from what the captured selection produces.
- R3: Codes 1..6 select register lengths 6, 9, 11, 15, 20 and 23 with second taps 5, 5, 9, 14, 3 and 18. At start the register `s` is set to all ones. For each bit, the output is `b = s[L-1] ^ s[T-1]`, and then `s` shifts left by one with `b` entering bit 0.
- R4: Code 0 is the quasi-random sequence. It uses the code 5 sequence, but a zero is replaced by a one when the 14 previously emitted bits are all zero, so no run of 15 zeros is ever sent.
- R5: Code 7 repeats the word 1 followed by seven 0s. Code 8 repeats the 24-bit word 0x440004, sent MSB first, whose ones fall at positions 1, 5 and 21 of each period.
- R6: Code 9 sends 1, 0, 1, 0, and so on, starting with 1.
- R7: Code 10 (clear) sends the value of `rx_bit` that was present in the strobe cycle.
- R8: One bit is emitted per cycle with `bit_en`=1 during a test. It appears on `tx_bit` at the clock edge that ends that cycle and holds until the next emitted bit. A cycle with `start`=1 emits no bit.
- R9: `stop`=1 ends the test at the next edge, and `tx_bit` becomes 1. When `start` and `stop` are high together, `stop` wins.
- R10: `len_limit`=0 runs without limit. A value N>0 allows exactly N bits. The next strobe cycle after the N-th bit ends the test, with `tx_bit`=1.
- R11: A `start` during a running test restarts it. Registers are re-seeded, word phases go back to the first bit, and the bit count is cleared.
- R12: Codes 11..15 send all ones for as long as the test runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit strobe; one bit per high cycle |
| pat_sel | input | 4 | Pattern code, captured at start |
| start | input | 1 | Begin or restart a test |
| stop | input | 1 | End the test |
| len_limit | input | CNT_W | Bit budget, captured at start; 0 means continuous |
| rx_bit | input | 1 | Received bit used in clear mode |
| tx_bit | output | 1 | Serial test bit |

## Verification
A corrupted shift register or a wrong tap changes the sequence within a handful of strobes. The bench compares every emitted bit against its own model, so such a fault shows at the first bad bit. A wrong zero-run count stays hidden until the quasi-random sequence reaches a long zero run, so that pattern runs for well over a hundred thousand bits. An error in the capture of the selection or the bit budget shows at the first strobe after a start, at the first strobe after the select lines move, or at the strobe just past the budget.

// File: rtl/bert_pkg.sv
package bert_pkg;

    typedef enum logic [3:0] {
        PAT_QRSS   = 4'd0,
        PAT_PN6    = 4'd1,
        PAT_PN9    = 4'd2,
        PAT_PN11   = 4'd3,
        PAT_PN15   = 4'd4,
        PAT_PN20   = 4'd5,
        PAT_PN23   = 4'd6,
        PAT_D1IN8  = 4'd7,
        PAT_D3IN24 = 4'd8,
        PAT_ALT    = 4'd9,
        PAT_CLEAR  = 4'd10
    } pat_e;

    localparam int NUM_PN   = 6;
    localparam int PN_LEN [NUM_PN] = '{6, 9, 11, 15, 20, 23};
    localparam int PN_TAP [NUM_PN] = '{5, 5, 9, 14, 3, 18};
    localparam int QRSS_IDX = 4;

    localparam int W8_LEN  = 8;
    localparam int W24_LEN = 24;
    localparam logic [W8_LEN-1:0]  WORD_1IN8  = 8'h80;
    localparam logic [W24_LEN-1:0] WORD_3IN24 = 24'h440004;

    // Map a pattern code to the shift-register bank index it draws from.
    function automatic logic [2:0] pn_index(input logic [3:0] code);
        if (code == PAT_QRSS)
            return 3'(QRSS_IDX);
        else if (code >= PAT_PN6 && code <= PAT_PN23)
            return 3'(code - 4'd1);
        else
            return 3'd0;
    endfunction

endpackage

// File: rtl/bert_lfsr.sv
module bert_lfsr #(
    parameter int LEN = 6,
    parameter int TAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seed_i,
    input  logic step_i,
    output logic bit_o
);

    typedef struct packed {
        logic [LEN-1:0] st;
    } lfsr_s;

    lfsr_s state_d, state_q;
    logic  fb;

    assign fb    = state_q.st[LEN-1] ^ state_q.st[TAP-1];
    assign bit_o = fb;

    always_comb begin
        state_d = state_q;
        if (seed_i)
            state_d.st = '1;
        else if (step_i)
            state_d.st = {state_q.st[LEN-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q.st <= '1;
        else
            state_q <= state_d;
    end

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.st != '0);

endmodule

// File: rtl/bert_pn_bank.sv
module bert_pn_bank
    import bert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_i,
    input  logic              step_i,
    output logic [NUM_PN-1:0] bits_o
);

    for (genvar g = 0; g < NUM_PN; g++) begin : g_pn
        bert_lfsr #(
            .LEN (PN_LEN[g]),
            .TAP (PN_TAP[g])
        ) i_lfsr (
            .clk    (clk),
            .rst_n  (rst_n),
            .seed_i (seed_i),
            .step_i (step_i),
            .bit_o  (bits_o[g])
        );
    end

endmodule

// File: rtl/bert_word_gen.sv
module bert_word_gen
    import bert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic one8_o,
    output logic three24_o,
    output logic alt_o
);

    localparam int P8W  = $clog2(W8_LEN);
    localparam int P24W = $clog2(W24_LEN);

    typedef struct packed {
        logic [P8W-1:0]  ph8;
        logic [P24W-1:0] ph24;
    } phase_s;

    phase_s ph_d, ph_q;

    assign one8_o    = WORD_1IN8[P8W'(W8_LEN - 1) - ph_q.ph8];
    assign three24_o = WORD_3IN24[P24W'(W24_LEN - 1) - ph_q.ph24];
    assign alt_o     = ~ph_q.ph8[0];

    always_comb begin
        ph_d = ph_q;
        if (clr_i) begin
            ph_d.ph8  = '0;
            ph_d.ph24 = '0;
        end else if (step_i) begin
            ph_d.ph8  = ph_q.ph8 + 1'b1;
            ph_d.ph24 = (ph_q.ph24 == P24W'(W24_LEN - 1)) ? '0 : ph_q.ph24 + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q.ph8  <= '0;
            ph_q.ph24 <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    // R5
    phase24_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.ph24 < P24W'(W24_LEN));

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int ZRUN_MAX = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [3:0]       pat_sel,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] len_limit,
    input  logic             rx_bit,
    output logic             tx_bit
);

    localparam int ZW = $clog2(ZRUN_MAX + 1);

    typedef struct packed {
        logic             active;
        logic [3:0]       sel;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic [ZW-1:0]    zrun;
        logic             tx;
    } ctl_s;

    ctl_s              q, d;
    logic              seed, step;
    logic [NUM_PN-1:0] pn_bits;
    logic              w_one8, w_three24, w_alt;
    logic              pn_bit, qrss_bit, pat_bit;
    logic              expired, emit;

    bert_pn_bank i_pn_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed),
        .step_i (step),
        .bits_o (pn_bits)
    );

    bert_word_gen i_word_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (seed),
        .step_i    (step),
        .one8_o    (w_one8),
        .three24_o (w_three24),
        .alt_o     (w_alt)
    );

    assign pn_bit   = pn_bits[pn_index(q.sel)];
    assign qrss_bit = pn_bit | (q.zrun == ZW'(ZRUN_MAX));
    assign expired  = (q.len != '0) && (q.cnt == q.len);
    assign emit     = q.active && bit_en && !start && !stop && !expired;

    always_comb begin
        unique case (q.sel)
            PAT_QRSS:   pat_bit = qrss_bit;
            PAT_PN6, PAT_PN9, PAT_PN11,
            PAT_PN15, PAT_PN20, PAT_PN23:
                        pat_bit = pn_bit;
            PAT_D1IN8:  pat_bit = w_one8;
            PAT_D3IN24: pat_bit = w_three24;
            PAT_ALT:    pat_bit = w_alt;
            PAT_CLEAR:  pat_bit = rx_bit;
            default:    pat_bit = 1'b1;
        endcase
    end

    always_comb begin
        d    = q;
        seed = 1'b0;
        step = 1'b0;
        if (stop) begin
            d.active = 1'b0;
            d.tx     = 1'b1;
        end else if (start) begin
            d.active = 1'b1;
            d.sel    = pat_sel;
            d.len    = len_limit;
            d.cnt    = '0;
            d.zrun   = '0;
            d.tx     = 1'b1;
            seed     = 1'b1;
        end else if (q.active && bit_en) begin
            if (expired) begin
                d.active = 1'b0;
                d.tx     = 1'b1;
            end else begin
                step  = 1'b1;
                d.cnt = q.cnt + 1'b1;
                d.tx  = pat_bit;
                if (q.sel == PAT_QRSS)
                    d.zrun = qrss_bit ? '0 : q.zrun + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.sel    <= '0;
            q.len    <= '0;
            q.cnt    <= '0;
            q.zrun   <= '0;
            q.tx     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_bit = q.tx;

    // R1
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> tx_bit);

    // R2
    sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(q.sel));

    // R4
    qrss_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && q.sel == PAT_QRSS && q.zrun == ZW'(ZRUN_MAX)) |=> tx_bit);

    // R7
    clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && q.sel == PAT_CLEAR) |=> tx_bit == $past(rx_bit));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !start && !stop) |=> $stable(tx_bit));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!q.active && tx_bit));

endmodule

// File: tb/test_bert_patgen.sv
`timescale 1ns/1ps
module test_bert_patgen;

    localparam time CLK_P = 20ns;
    localparam int  CNT_W = 32;

    typedef struct packed {
        logic [3:0]  code;
        logic [31:0] nbits;
        logic [7:0]  gap;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'd120000, 8'd0},
        '{4'd1,  32'd200,    8'd1},
        '{4'd2,  32'd600,    8'd0},
        '{4'd3,  32'd300,    8'd2},
        '{4'd4,  32'd300,    8'd0},
        '{4'd5,  32'd300,    8'd1},
        '{4'd6,  32'd300,    8'd0},
        '{4'd7,  32'd64,     8'd1},
        '{4'd8,  32'd96,     8'd0},
        '{4'd9,  32'd40,     8'd2},
        '{4'd10, 32'd200,    8'd0},
        '{4'd13, 32'd50,     8'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic [3:0]       pat_sel = '0;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic [CNT_W-1:0] len_limit = '0;
    logic             rx_bit = 1'b0;
    logic             tx_bit;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // bench model state
    int          m_code;
    logic [22:0] m_s;
    int          m_zrun;
    int          m_ph;

    always #(CLK_P/2) clk = ~clk;

    bert_patgen #(.CNT_W(CNT_W), .ZRUN_MAX(14)) i_bert_patgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .pat_sel   (pat_sel),
        .start     (start),
        .stop      (stop),
        .len_limit (len_limit),
        .rx_bit    (rx_bit),
        .tx_bit    (tx_bit)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: tx_bit=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic void model_seed(input int code);
        m_code = code;
        m_s    = '1;
        m_zrun = 0;
        m_ph   = 0;
    endfunction

    function automatic logic model_next(input logic rx);
        int   l, t, p;
        logic b;
        b = 1'b1;
        if (m_code <= 6) begin
            case (m_code)
                0, 5: begin l = 20; t = 3;  end
                1:    begin l = 6;  t = 5;  end
                2:    begin l = 9;  t = 5;  end
                3:    begin l = 11; t = 9;  end
                4:    begin l = 15; t = 14; end
                default: begin l = 23; t = 18; end
            endcase
            b   = m_s[l-1] ^ m_s[t-1];
            m_s = ((m_s << 1) | 23'(b)) & 23'((1 << l) - 1);
            if (m_code == 0) begin
                if (!b && m_zrun == 14) b = 1'b1;
                m_zrun = b ? 0 : m_zrun + 1;
            end
        end else if (m_code == 7) begin
            b = (m_ph % 8) == 0;
        end else if (m_code == 8) begin
            p = m_ph % 24;
            b = (p == 1) || (p == 5) || (p == 21);
        end else if (m_code == 9) begin
            b = (m_ph % 2) == 0;
        end else if (m_code == 10) begin
            b = rx;
        end
        m_ph++;
        return b;
    endfunction

    task automatic do_start(input int code, input int len, input string req);
        pat_sel   = 4'(code);
        len_limit = CNT_W'(len);
        start     = 1'b1;
        tick();
        start = 1'b0;
        model_seed(code);
        chk(req, tx_bit, 1'b1);
    endtask

    task automatic emit_bit(input string req);
        logic r, e;
        r      = 1'($urandom_range(0, 1));
        rx_bit = r;
        bit_en = 1'b1;
        e      = model_next(r);
        tick();
        bit_en = 1'b0;
        chk(req, tx_bit, e);
    endtask

    task automatic do_stop();
        stop = 1'b1;
        tick();
        stop = 1'b0;
        chk("R9 stop", tx_bit, 1'b1);
    endtask

    initial begin
        #(CLK_P * 195000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic prev;
        // R1: reset state and idle behaviour
        repeat (3) tick();
        chk("R1 reset", tx_bit, 1'b1);
        rst_n = 1'b1;
        tick();
        for (int k = 0; k < 5; k++) begin
            pat_sel = 4'(k + 7);
            bit_en  = 1'b1;
            tick();
            chk("R2 idle select ignored", tx_bit, 1'b1);
        end
        bit_en = 1'b0;

        // vector table
        for (int v = 0; v < NV; v++) begin
            do_start(int'(VECS[v].code), 0, "R8 start emits nothing");
            for (int n = 0; n < int'(VECS[v].nbits); n++) begin
                case (VECS[v].code)
                    4'd0:         emit_bit("R4 qrss");
                    4'd7, 4'd8:   emit_bit("R5 density");
                    4'd9:         emit_bit("R6 alt");
                    4'd10:        emit_bit("R7 clear");
                    4'd13:        emit_bit("R12 unused code");
                    default:      emit_bit("R3 prbs");
                endcase
                prev = tx_bit;
                for (int g = 0; g < int'(VECS[v].gap); g++) begin
                    tick();
                    chk("R8 hold between strobes", tx_bit, prev);
                end
            end
            do_stop();
        end

        // R2: select change during a test has no effect
        do_start(1, 0, "R2 start");
        for (int n = 0; n < 20; n++) emit_bit("R2 before change");
        pat_sel = 4'd9;
        for (int n = 0; n < 20; n++) emit_bit("R2 select moved");
        do_stop();
        for (int n = 0; n < 4; n++) begin
            bit_en = 1'b1;
            tick();
            chk("R1 idle after stop", tx_bit, 1'b1);
        end
        bit_en = 1'b0;

        // R9: stop wins over simultaneous start (code 1 would give 0 first)
        pat_sel = 4'd1;
        start   = 1'b1;
        stop    = 1'b1;
        tick();
        start = 1'b0;
        stop  = 1'b0;
        bit_en = 1'b1;
        tick();
        bit_en = 1'b0;
        chk("R9 stop beats start", tx_bit, 1'b1);

        // R10: bit budget
        do_start(1, 10, "R10 start");
        for (int n = 0; n < 10; n++) emit_bit("R10 within budget");
        for (int n = 0; n < 3; n++) begin
            bit_en = 1'b1;
            tick();
            chk("R10 budget exhausted", tx_bit, 1'b1);
        end
        bit_en = 1'b0;
        do_start(7, 1, "R10 start one");
        emit_bit("R10 single bit");
        bit_en = 1'b1;
        tick();
        bit_en = 1'b0;
        chk("R10 after single bit", tx_bit, 1'b1);

        // R11: restart mid-test
        do_start(2, 0, "R11 first start");
        for (int n = 0; n < 15; n++) emit_bit("R11 first run");
        do_start(2, 0, "R11 restart");
        for (int n = 0; n < 15; n++) emit_bit("R11 after restart");
        do_start(8, 0, "R11 restart word");
        for (int n = 0; n < 30; n++) emit_bit("R11 word phase");
        do_stop();

        // R8: start together with strobe emits no bit
        pat_sel = 4'd1;
        start   = 1'b1;
        bit_en  = 1'b1;
        tick();
        start  = 1'b0;
        bit_en = 1'b0;
        model_seed(1);
        chk("R8 start with strobe", tx_bit, 1'b1);
        for (int n = 0; n < 8; n++) emit_bit("R8 first bits after start");

        // R1: reset during a test
        rst_n = 1'b0;
        tick();
        chk("R1 reset mid-test", tx_bit, 1'b1);
        rst_n = 1'b1;
        bit_en = 1'b1;
        tick();
        bit_en = 1'b0;
        chk("R1 idle after reset", tx_bit, 1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule